// File: doc/BRIEF.md
# Johnson-Ring Decade Sequencer

A synchronous ten-step sequencer. Its count state is a five-stage twisted-ring (Johnson) shift register, so the state runs through ten distinct patterns before it repeats. Each pattern is decoded into one of ten one-hot outputs using a two-bit term on adjacent ring stages. On every counted rising clock edge the single active output moves one place forward, from output 0 up to output 9, and then wraps back to output 0.

A pause input (`hold`) freezes the state and ignores clock edges for as long as it is high. Counting picks up from the same step when `hold` returns low. The logic is fully static, so the state is kept for any length of time with no minimum clock rate. An asynchronous active-low reset returns the sequence to output 0. The reset tree of the system is expected to release it synchronously to `clk`.

A carry output is taken from the last ring stage. It is high during the first half of the cycle and low during the second half, so it rises once per ten counted edges, on the step back to output 0. A following unit can use that edge to advance once per full cycle. Any of the 22 ring patterns that are not part of the cycle is flushed to the output-0 state on the next counted edge.

Top module: `johnson_decade_seq`

## Requirements
- R1: While `rst_n` is low, `phase` equals 10'b00_0000_0001 and `carry_out` is 1, whatever `clk` and `hold` do. The reset takes effect at once, without waiting for a clock edge.
- R2: Bit k of `phase` means output k is active. In normal operation exactly one bit of `phase` is 1 at all times.
- R3: On each rising edge of `clk` with `rst_n` high and `hold` low, the active output moves from index k to index (k+1) mod 10. It then stays active for one full clock period.
- R4: While `hold` is 1, rising clock edges leave `phase` and `carry_out` unchanged. When `hold` returns to 0, counting resumes from the step that was held.
- R5: `carry_out` is 1 while output 0, 1, 2, 3 or 4 is active and 0 while output 5, 6, 7, 8 or 9 is active. It therefore rises exactly once per ten counted edges, in the same cycle that output 0 becomes active.
- R6: After `rst_n` is released, the first counted rising edge makes output 1 active.
- R7: If the ring holds any 5-bit pattern outside the ten legal ones, the next counted edge returns it to the all-zero pattern (output 0 active, `carry_out` 1). Counting then continues normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to output 0 |
| hold | input | 1 | Active-high pause; counting edges are ignored while high |
| phase | output | 10 | One-hot step outputs; bit k is output k |
| carry_out | output | 1 | High for steps 0 to 4, low for steps 5 to 9 |

## Verification
On every cycle the assertions check the following:
- the one-hot shape of `phase` whenever the ring is legal;
- the single-place rotation on a counted edge and the frozen outputs under `hold`;
- the tie between `carry_out` and the half of the cycle that is active;
- the forced output 0 during reset and the flush of an illegal ring to all zeros.

Other properties need the bench's scenarios:
- that the decoded step matches a count from reset over several wraps;
- the exact number of carry rises;
- that reset acts asynchronously, between clock edges;
- that each of the 22 illegal patterns, injected into the ring, recovers.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

  localparam int unsigned DEF_STAGES = 5;

  // Number of positions where neighbouring bits differ, over the low n bits.
  function automatic int unsigned adj_flips(input logic [31:0] v, input int unsigned n);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned i = 0; i + 1 < n; i++) begin
      if (v[i] != v[i+1]) cnt++;
    end
    return cnt;
  endfunction

endpackage

// File: rtl/seq_ring_guard.sv
`timescale 1ns/1ps
module seq_ring_guard #(
  parameter int unsigned STAGES = seq_pkg::DEF_STAGES
) (
  input  logic [STAGES-1:0] ring,
  output logic              legal
);
  // A legal twisted-ring pattern is one block of ones and one block of zeros,
  // so there is at most one flip between neighbouring stages.
  always_comb begin
    legal = (seq_pkg::adj_flips(32'(ring), STAGES) <= 1);
  end
endmodule

// File: rtl/seq_ring.sv
`timescale 1ns/1ps
module seq_ring #(
  parameter int unsigned STAGES = seq_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              legal,
  output logic [STAGES-1:0] state_q
);
  logic [STAGES-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (advance) begin
      if (legal) state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
      else       state_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= '0;
    else if (advance) state_q <= state_d;
  end

  // R7
  illegal_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !legal) |=> (state_q == '0));

endmodule

// File: rtl/seq_decode.sv
`timescale 1ns/1ps
module seq_decode #(
  parameter int unsigned STAGES = seq_pkg::DEF_STAGES,
  localparam int unsigned OUTS = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring,
  output logic [OUTS-1:0]   phase
);
  // Both ends low: step 0. Both ends high: step STAGES.
  assign phase[0]      = ~ring[0] & ~ring[STAGES-1];
  assign phase[STAGES] =  ring[0] &  ring[STAGES-1];

  // A rising front of ones marks the filling half of the cycle. A falling
  // front marks the emptying half.
  for (genvar k = 1; k < STAGES; k++) begin : g_pair
    assign phase[k]          =  ring[k-1] & ~ring[k];
    assign phase[STAGES + k] = ~ring[k-1] &  ring[k];
  end
endmodule

// File: rtl/johnson_decade_seq.sv
`timescale 1ns/1ps
module johnson_decade_seq #(
  parameter int unsigned STAGES = seq_pkg::DEF_STAGES,
  localparam int unsigned OUTS = 2 * STAGES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  output logic [OUTS-1:0] phase,
  output logic            carry_out
);
  logic [STAGES-1:0] ring_q;
  logic              ring_ok;
  logic              count_en;

  assign count_en = ~hold;

  seq_ring_guard #(.STAGES(STAGES)) u_guard (
    .ring  (ring_q),
    .legal (ring_ok)
  );

  seq_ring #(.STAGES(STAGES)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (count_en),
    .legal   (ring_ok),
    .state_q (ring_q)
  );

  seq_decode #(.STAGES(STAGES)) u_dec (
    .ring  (ring_q),
    .phase (phase)
  );

  assign carry_out = ~ring_q[STAGES-1];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (phase == OUTS'(1) && carry_out));

  // R2
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_ok |-> $onehot(phase));

  // R3
  step_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && ring_ok) |=> (!ring_ok ||
      phase == {$past(phase[OUTS-2:0]), $past(phase[OUTS-1])}));

  // R4
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!ring_ok || ($stable(phase) && $stable(carry_out))));

  // R5
  carry_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_ok |-> (carry_out == (phase[STAGES-1:0] != '0)));

  // R5
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_ok && $rose(carry_out)) |-> phase[0]);

endmodule

// File: tb/test_johnson_decade_seq.sv
`timescale 1ns/1ps
module test_johnson_decade_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       hold = 1'b0;
  logic [9:0] phase;
  logic       carry_out;
  logic [4:0] inj;

  int total = 0;
  int bad = 0;
  int ref_n = 0;
  int seen_rises = 0;
  int exp_rises = 0;
  logic prev_carry = 1'b1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  johnson_decade_seq i_johnson_decade_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .phase     (phase),
    .carry_out (carry_out)
  );

  task automatic check(input string req);
    logic [9:0] e;
    logic ec;
    e  = 10'(1) << ref_n;
    ec = (ref_n < 5);
    total++;
    if (phase !== e || carry_out !== ec) begin
      bad++;
      $display("FAIL %s: phase=%b exp=%b carry=%b exp=%b", req, phase, e, carry_out, ec);
    end
  endtask

  // Entered and left at a falling edge.
  task automatic tick(input logic h, input string req);
    hold = h;
    @(posedge clk);
    if (rst_n && !h) begin
      ref_n = (ref_n + 1) % 10;
      if (ref_n == 0) exp_rises++;
    end
    @(negedge clk);
    if (carry_out && !prev_carry) seen_rises++;
    prev_carry = carry_out;
    check(req);
  endtask

  function automatic bit pat_legal(input int p);
    int n;
    n = 0;
    for (int i = 0; i < 4; i++) if (((p >> i) & 1) != ((p >> (i + 1)) & 1)) n++;
    return n <= 1;
  endfunction

  initial begin
    #2 rst_n = 1'b0;
    @(negedge clk);
    check("R1");
    tick(1'b1, "R1");
    tick(1'b0, "R1");
    rst_n = 1'b1;
    tick(1'b0, "R6");

    // R3 R5: several wraps with free counting
    for (int i = 0; i < 28; i++) tick(1'b0, "R3");
    total++;
    if (seen_rises != exp_rises || exp_rises != 2) begin
      bad++;
      $display("FAIL R5: carry rises=%0d exp=%0d", seen_rises, exp_rises);
    end

    // R4: long pause in the second half, then resume
    for (int i = 0; i < 6; i++) tick(1'b1, "R4");
    tick(1'b0, "R4");
    tick(1'b0, "R4");

    // Randomised pauses and asynchronous reset pulses
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 37 == 0) begin
        rst_n = 1'b0;
        #1;
        ref_n = 0;
        check("R1");
        tick(1'b0, "R1");
        rst_n = 1'b1;
        tick(1'b0, "R6");
      end else if ($urandom % 3 == 0) begin
        tick(1'b1, "R4");
      end else begin
        tick(1'b0, "R3");
      end
    end

    // R7: inject every illegal ring pattern
    for (int p = 0; p < 32; p++) begin
      if (!pat_legal(p)) begin
        hold = 1'b0;
        inj = 5'(p);
        force i_johnson_decade_seq.u_ring.state_q = inj;
        #1;
        release i_johnson_decade_seq.u_ring.state_q;
        @(posedge clk);
        ref_n = 0;
        @(negedge clk);
        check("R7");
        tick(1'b0, "R7");
      end
    end
    for (int i = 0; i < 12; i++) tick(1'b0, "R3");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule